// File: doc/BRIEF.md
# Radio packet byte FIFO with interrupt sources

This block is the byte buffer between a host register port and the bit-level datapath of a packet radio. While receiving, a shift register hands over each completed byte and the host drains the buffer. While transmitting, the host loads bytes and an internal serializer shifts them out one bit per bit-rate strobe, most significant bit first, toward the modulator.

The block drives level interrupt sources for the host: an active-low empty indication, full, a programmable fill threshold, a byte-written pulse and transmit-done. It also keeps a sticky overrun flag. Writing 1 to the overrun flag clears it and empties the buffer. Each change of operating mode (sleep, standby, receive, transmit) either keeps or discards the buffered bytes. The rule depends on which modes are involved and, for one transition, on whether packet or buffered data mode is selected.

Top module: `rfByteFifo`

## Requirements
- R1: `irqEmptyN` is 0 when the buffer holds no byte and 1 when it holds at least one.
- R2: `irqFull` is 1 exactly when the buffer holds DEPTH bytes (64 by default).
- R3: `irqThresh` is 1 when the fill count is greater than `thresh` and 0 when the count is `thresh` or less.
- R4: Bytes leave in the order they entered. A push and a pop in the same cycle leave the fill count unchanged.
- R5: The shift register's byte is taken only in receive mode (`opMode` = 2). Each accepted byte sets `irqByteWr` on the next cycle. It stays 1 until the cycle after the next `bitTick`, so when the byte arrives with a strobe the pulse lasts one bit period.
- R6: A write attempted while the buffer is full discards the byte and sets `ovrFlag`. The flag stays set until it is cleared.
- R7: A cycle with `ovrClrWr` = 1 clears `ovrFlag` and empties the buffer.
- R8: Host writes are accepted in transmit (`opMode` = 3). They are accepted in standby (`opMode` = 1) only when `pktMode` = 1. Host reads have no effect in transmit.
- R9: In transmit, each `bitTick` drives the next bit onto `txBit`, MSB first. The next buffered byte is taken on the strobe after the previous byte's last bit, with no idle strobe between bytes.
- R10: `txDone` rises on the edge that drives the final bit of a byte onto `txBit` if the buffer is then empty. It stays 1 until a host write is accepted or the buffer is flushed.
- R11: Entering sleep (`opMode` = 0) empties the buffer. Receive to standby keeps the contents. Standby to transmit keeps the contents when `pktMode` = 1 and empties the buffer when `pktMode` = 0.
- R12: Standby to receive, receive to transmit, transmit to receive and transmit to standby empty the buffer and clear `ovrFlag`. A push in the cycle of such a change is dropped.
- R13: After reset the buffer is empty and `ovrFlag`, `txDone`, `txBit` and `irqByteWr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 2 | Operating mode: 0 sleep, 1 standby, 2 receive, 3 transmit |
| pktMode | input | 1 | 1 packet data mode, 0 buffered data mode |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | DATA_W | Host write byte |
| hostRdEn | input | 1 | Host byte read strobe (pops the head) |
| hostRdData | output | DATA_W | Byte at the head of the buffer |
| ovrClrWr | input | 1 | Host writes 1 to the overrun flag |
| thresh | input | log2(DEPTH) | Threshold value B |
| srValid | input | 1 | Receive shift register has a completed byte |
| srByte | input | DATA_W | Completed receive byte |
| bitTick | input | 1 | Bit-rate strobe |
| txBit | output | 1 | Serial bit to the modulator |
| txDone | output | 1 | Transmit-done level |
| irqEmptyN | output | 1 | Active-low empty source |
| irqFull | output | 1 | Full source |
| irqThresh | output | 1 | Fill count above threshold |
| irqByteWr | output | 1 | Byte-written pulse |
| ovrFlag | output | 1 | Sticky overrun flag |

## Verification
A corrupted read or write pointer shows on `hostRdData` at the next host read, or on `txBit` within eight strobes, as a byte out of order. A wrong fill count shows on the same edge through the empty, full and threshold sources. A mode-transition rule that wrongly keeps or discards data shows as a wrong `irqEmptyN` level on the cycle after the mode change. A serializer that is off by one bit shows as a misaligned byte, and as `txDone` rising one strobe early or late.

// File: rtl/rfFifoPkg.sv
package rfFifoPkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_RX    = 2'd2,
    MODE_TX    = 2'd3
  } opMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic push;
    logic pushFromSr;
    logic pop;
  } fifoStrb_t;

endpackage

// File: rtl/rfFifoPath.sv
module rfFifoPath import rfFifoPkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [DATA_W-1:0] hostByte,
  input  logic [DATA_W-1:0] srByte,
  output logic [DATA_W-1:0] headByte,
  output logic [CNT_W-1:0]  fillCount
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] inByte;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign inByte   = strb.pushFromSr ? srByte : hostByte;
  assign headByte = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

endmodule

// File: rtl/rfFifoCtrl.sv
module rfFifoCtrl import rfFifoPkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  opMode_e           opMode,
  input  logic              pktMode,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              srValid,
  input  logic              ovrClrWr,
  input  logic              bitTick,
  input  logic [CNT_W-2:0]  thresh,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic [DATA_W-1:0] headByte,
  output fifoStrb_t         strb,
  output logic              ovrFlag,
  output logic              txBit,
  output logic              txDone,
  output logic              irqByteWr,
  output logic              irqThresh,
  output logic              irqFull,
  output logic              irqEmptyN
);

  opMode_e           prevMode;
  logic              modeFlush, flushNow;
  logic              isEmpty, isFull;
  logic              hostPushReq, srPushReq, pushReq, pushOk, hostPushOk;
  logic              hostPop, serPop, txSlot, txShift;
  logic [DATA_W-1:0] shReg;
  logic [BIT_W-1:0]  bitsLeft;

  assign isEmpty   = (fillCount == '0);
  assign isFull    = (fillCount == CNT_W'(DEPTH));
  assign irqEmptyN = !isEmpty;
  assign irqFull   = isFull;
  assign irqThresh = fillCount > {1'b0, thresh};

  // transition rules that discard the buffer
  always_comb begin
    modeFlush = 1'b0;
    if (opMode != prevMode) begin
      case ({prevMode, opMode})
        {MODE_STBY, MODE_RX}: modeFlush = 1'b1;
        {MODE_STBY, MODE_TX}: modeFlush = !pktMode;
        {MODE_RX,   MODE_TX}: modeFlush = 1'b1;
        {MODE_TX,   MODE_RX}: modeFlush = 1'b1;
        {MODE_TX,   MODE_STBY}: modeFlush = 1'b1;
        default:              modeFlush = (opMode == MODE_SLEEP);
      endcase
    end
  end

  assign flushNow    = modeFlush || ovrClrWr;
  assign hostPushReq = hostWrEn && ((opMode == MODE_TX) || ((opMode == MODE_STBY) && pktMode));
  assign srPushReq   = srValid && (opMode == MODE_RX);
  assign pushReq     = hostPushReq || srPushReq;
  assign pushOk      = pushReq && !isFull && !flushNow;
  assign hostPushOk  = pushOk && hostPushReq;
  assign hostPop     = hostRdEn && !isEmpty && (opMode != MODE_TX) && !flushNow;
  assign txSlot      = (opMode == MODE_TX) && bitTick && !flushNow;
  assign txShift     = txSlot && (bitsLeft != '0);
  assign serPop      = txSlot && (bitsLeft == '0) && !isEmpty;

  always_comb begin
    strb            = '0;
    strb.flush      = flushNow;
    strb.push       = pushOk;
    strb.pushFromSr = srPushReq;
    strb.pop        = hostPop || serPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMode <= MODE_SLEEP;
    else       prevMode <= opMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ovrFlag <= 1'b0;
    else if (flushNow)               ovrFlag <= 1'b0;
    else if (pushReq && isFull)      ovrFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       irqByteWr <= 1'b0;
    else if (flushNow)               irqByteWr <= 1'b0;
    else if (pushOk && srPushReq)    irqByteWr <= 1'b1;
    else if (bitTick)                irqByteWr <= 1'b0;
  end

  // serializer: MSB first, one bit per strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      txBit    <= 1'b0;
      txDone   <= 1'b0;
    end else if (flushNow) begin
      shReg    <= '0;
      bitsLeft <= '0;
      txBit    <= 1'b0;
      txDone   <= 1'b0;
    end else begin
      if (serPop) begin
        txBit    <= headByte[DATA_W-1];
        shReg    <= headByte << 1;
        bitsLeft <= BIT_W'(DATA_W - 1);
      end else if (txShift) begin
        txBit    <= shReg[DATA_W-1];
        shReg    <= shReg << 1;
        bitsLeft <= bitsLeft - 1'b1;
      end
      if (hostPushOk)
        txDone <= 1'b0;
      else if (txShift && (bitsLeft == BIT_W'(1)) && isEmpty)
        txDone <= 1'b1;
    end
  end

endmodule

// File: rtl/rfByteFifo.sv
module rfByteFifo import rfFifoPkg::*; #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opMode,
  input  logic              pktMode,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              ovrClrWr,
  input  logic [CNT_W-2:0]  thresh,
  input  logic              srValid,
  input  logic [DATA_W-1:0] srByte,
  input  logic              bitTick,
  output logic              txBit,
  output logic              txDone,
  output logic              irqEmptyN,
  output logic              irqFull,
  output logic              irqThresh,
  output logic              irqByteWr,
  output logic              ovrFlag
);

  fifoStrb_t        strb;
  logic [CNT_W-1:0] fillCount;

  rfFifoCtrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opMode    (opMode_e'(opMode)),
    .pktMode   (pktMode),
    .hostWrEn  (hostWrEn),
    .hostRdEn  (hostRdEn),
    .srValid   (srValid),
    .ovrClrWr  (ovrClrWr),
    .bitTick   (bitTick),
    .thresh    (thresh),
    .fillCount (fillCount),
    .headByte  (hostRdData),
    .strb      (strb),
    .ovrFlag   (ovrFlag),
    .txBit     (txBit),
    .txDone    (txDone),
    .irqByteWr (irqByteWr),
    .irqThresh (irqThresh),
    .irqFull   (irqFull),
    .irqEmptyN (irqEmptyN)
  );

  rfFifoPath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostByte  (hostWrData),
    .srByte    (srByte),
    .headByte  (hostRdData),
    .fillCount (fillCount)
  );

endmodule

// File: rtl/rfByteFifoChk.sv
module rfByteFifoChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] opMode,
  input logic       ovrClrWr,
  input logic       bitTick,
  input logic       txBit,
  input logic       txDone,
  input logic       irqEmptyN,
  input logic       irqFull,
  input logic       irqThresh,
  input logic       irqByteWr,
  input logic       ovrFlag
);

  p_full_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqFull |-> irqEmptyN);

  p_thresh_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqThresh |-> irqEmptyN);

  p_bytewr_rx_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqByteWr) |-> ($past(opMode) == 2'd2));

  p_ovr_from_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(irqFull));

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovrClrWr |=> (!ovrFlag && !irqEmptyN));

  p_txbit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !ovrClrWr && $stable(opMode)) |=> $stable(txBit));

  p_txdone_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !irqEmptyN);

  p_sleep_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'd0) |=> !irqEmptyN);

endmodule

bind rfByteFifo rfByteFifoChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opMode    (opMode),
  .ovrClrWr  (ovrClrWr),
  .bitTick   (bitTick),
  .txBit     (txBit),
  .txDone    (txDone),
  .irqEmptyN (irqEmptyN),
  .irqFull   (irqFull),
  .irqThresh (irqThresh),
  .irqByteWr (irqByteWr),
  .ovrFlag   (ovrFlag)
);

// File: tb/rfByteFifo_tb.sv
module rfByteFifo_tb;

  localparam logic [1:0] M_SLEEP = 2'd0, M_STBY = 2'd1, M_RX = 2'd2, M_TX = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] opMode = M_SLEEP;
  logic       pktMode = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic [7:0] hostRdData;
  logic       ovrClrWr = 1'b0;
  logic [5:0] thresh = '0;
  logic       srValid = 1'b0;
  logic [7:0] srByte = '0;
  logic       bitTick = 1'b0;
  logic       txBit, txDone, irqEmptyN, irqFull, irqThresh, irqByteWr, ovrFlag;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  rfByteFifo u_dut (
    .clk(clk), .rstN(rstN), .opMode(opMode), .pktMode(pktMode),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .ovrClrWr(ovrClrWr), .thresh(thresh),
    .srValid(srValid), .srByte(srByte), .bitTick(bitTick), .txBit(txBit),
    .txDone(txDone), .irqEmptyN(irqEmptyN), .irqFull(irqFull),
    .irqThresh(irqThresh), .irqByteWr(irqByteWr), .ovrFlag(ovrFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change 2 ns after the rising edge
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // driver: predicts acceptance and pushes expected bytes
  task automatic hostWrite(input logic [7:0] b);
    bit ok;
    ok = ((opMode == M_TX) || ((opMode == M_STBY) && pktMode)) && (expQ.size() < 64);
    hostWrEn = 1'b1;
    hostWrData = b;
    cyc();
    hostWrEn = 1'b0;
    if (ok) expQ.push_back(b);
  endtask

  task automatic srWrite(input logic [7:0] b);
    bit ok;
    ok = (opMode == M_RX) && (expQ.size() < 64);
    srValid = 1'b1;
    srByte = b;
    bitTick = 1'b1;
    cyc();
    srValid = 1'b0;
    bitTick = 1'b0;
    if (ok) expQ.push_back(b);
  endtask

  task automatic hostRead();
    hostRdEn = 1'b1;
    cyc();
    hostRdEn = 1'b0;
  endtask

  task automatic tick();
    bitTick = 1'b1;
    cyc();
    bitTick = 1'b0;
    cyc();
  endtask

  task automatic setMode(input logic [1:0] m);
    opMode = m;
    cyc();
  endtask

  // monitor: pops the scoreboard on host reads and on serialized bytes
  logic       emitNext = 1'b0;
  logic [7:0] txShiftIn = '0;
  int         txBitCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (emitNext) begin
        txShiftIn = {txShiftIn[6:0], txBit};
        txBitCnt++;
        if (txBitCnt == 8) begin
          txBitCnt = 0;
          if (expQ.size() == 0) chk("R9 tx byte with empty scoreboard", 1, 0);
          else chk("R9 serialized byte", int'(txShiftIn), int'(expQ.pop_front()));
        end
      end
      emitNext = bitTick && (opMode == M_TX) && (expQ.size() > 0);
      if (hostRdEn && irqEmptyN && (opMode != M_TX)) begin
        if (expQ.size() == 0) chk("R4 read with empty scoreboard", 1, 0);
        else chk("R4 read order", int'(hostRdData), int'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R13 reset empty", irqEmptyN, 0);
    chk("R13 reset ovr", ovrFlag, 0);
    chk("R13 reset txDone", txDone, 0);
    chk("R13 reset txBit", txBit, 0);
    chk("R13 reset byteWr", irqByteWr, 0);
    rstN = 1'b1;
    cyc();

    // buffered standby refuses host writes
    setMode(M_STBY);
    hostWrite(8'hA5);
    chk("R8 buffered standby write refused", irqEmptyN, 0);

    // packet standby: order and threshold
    pktMode = 1'b1;
    thresh = 6'd2;
    hostWrite(8'h11);
    hostWrite(8'h22);
    chk("R3 count equal B", irqThresh, 0);
    hostWrite(8'h33);
    chk("R3 count above B", irqThresh, 1);
    chk("R1 nonempty", irqEmptyN, 1);
    repeat (3) hostRead();
    chk("R1 empty after drain", irqEmptyN, 0);

    // full and overrun
    for (int i = 0; i < 63; i++) hostWrite(8'(i + 64));
    chk("R2 not full at 63", irqFull, 0);
    hostWrite(8'h7F);
    chk("R2 full at 64", irqFull, 1);
    hostWrite(8'hEE);
    chk("R6 overrun set", ovrFlag, 1);
    chk("R2 still full", irqFull, 1);
    repeat (64) hostRead();
    chk("R6 extra byte discarded", irqEmptyN, 0);
    chk("R6 overrun sticky", ovrFlag, 1);

    // write-1 clear flushes
    hostWrite(8'h01);
    hostWrite(8'h02);
    ovrClrWr = 1'b1;
    cyc();
    ovrClrWr = 1'b0;
    expQ.delete();
    chk("R7 overrun cleared", ovrFlag, 0);
    chk("R7 buffer flushed", irqEmptyN, 0);

    // standby -> receive clears
    hostWrite(8'h03);
    setMode(M_RX);
    expQ.delete();
    chk("R12 stby to rx flush", irqEmptyN, 0);

    // byte-written pulse
    srWrite(8'h5A);
    chk("R5 byteWr set", irqByteWr, 1);
    chk("R5 byte stored", irqEmptyN, 1);
    cyc();
    chk("R5 byteWr held between strobes", irqByteWr, 1);
    bitTick = 1'b1;
    cyc();
    bitTick = 1'b0;
    chk("R5 byteWr dropped after strobe", irqByteWr, 0);

    // simultaneous push and pop
    thresh = 6'd1;
    srWrite(8'h6B);
    chk("R3 two bytes above B=1", irqThresh, 1);
    srValid = 1'b1;
    srByte = 8'h7C;
    bitTick = 1'b1;
    hostRdEn = 1'b1;
    cyc();
    srValid = 1'b0;
    bitTick = 1'b0;
    hostRdEn = 1'b0;
    expQ.push_back(8'h7C);
    chk("R4 push+pop keeps count", irqThresh, 1);
    hostRead();
    chk("R4 count drops after pop", irqThresh, 0);

    // receive -> standby keeps, shift register ignored in standby
    setMode(M_STBY);
    chk("R11 rx to stby keeps", irqEmptyN, 1);
    srWrite(8'h99);
    hostRead();
    chk("R5 standby shift byte ignored", irqEmptyN, 0);

    // sleep clears
    hostWrite(8'h44);
    setMode(M_SLEEP);
    expQ.delete();
    chk("R11 sleep flush", irqEmptyN, 0);

    // packet mode standby -> transmit keeps, serialize
    setMode(M_STBY);
    hostWrite(8'hC3);
    hostWrite(8'h5A);
    setMode(M_TX);
    chk("R11 pkt stby to tx keeps", irqEmptyN, 1);
    repeat (15) tick();
    chk("R10 txDone low before last bit", txDone, 0);
    tick();
    chk("R10 txDone at last bit", txDone, 1);
    chk("R9 buffer drained", irqEmptyN, 0);
    repeat (3) cyc();
    chk("R10 txDone held", txDone, 1);
    hostWrite(8'h81);
    chk("R10 txDone cleared by write", txDone, 0);
    hostRead();
    chk("R8 read ignored in tx", irqEmptyN, 1);
    repeat (8) tick();
    chk("R10 txDone after next byte", txDone, 1);

    // transmit -> standby clears
    hostWrite(8'h42);
    setMode(M_STBY);
    expQ.delete();
    chk("R12 tx to stby flush", irqEmptyN, 0);
    chk("R10 txDone cleared by mode change", txDone, 0);

    // buffered standby -> transmit clears
    pktMode = 1'b0;
    setMode(M_RX);
    srWrite(8'h10);
    setMode(M_STBY);
    chk("R11 rx to stby keeps (buffered)", irqEmptyN, 1);
    setMode(M_TX);
    expQ.delete();
    chk("R11 buffered stby to tx flush", irqEmptyN, 0);

    // transmit -> receive clears overrun; push in change cycle dropped
    for (int i = 0; i < 65; i++) hostWrite(8'(i));
    chk("R6 overrun in tx", ovrFlag, 1);
    opMode = M_RX;
    srValid = 1'b1;
    srByte = 8'h77;
    bitTick = 1'b1;
    cyc();
    srValid = 1'b0;
    bitTick = 1'b0;
    expQ.delete();
    chk("R12 tx to rx clears overrun", ovrFlag, 0);
    chk("R12 push dropped on change", irqEmptyN, 0);
    chk("R12 no byteWr on change", irqByteWr, 0);

    repeat (4) cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule